// File: doc/BRIEF.md
# PCIe User Configuration Space Responder

This block sits next to the configuration logic of a PCI Express endpoint and serves configuration reads and writes that land in two fixed user windows. The legacy window covers byte addresses 0xC0 through 0xFF. The extended window covers byte addresses 0x400 through 0xFFF. Neither base can be moved. The surrounding logic presents one dword-addressed request at a time and receives exactly one completion pulse for each request the block claims.

A small register file backs the first few dwords of each window. Every other offset inside an enabled window still completes successfully. A read of such an offset returns zero, and a write to it is dropped. The extended window is claimed only while both its own enable and the serial-number capability enable are high. A request outside both windows, or inside a window that is switched off, is left untouched so that other logic can answer it.

Top module: `ucfg_responder`

## Requirements
- R1: After a synchronous reset, `done` is low, `rdata` is zero and every implemented register reads 0x00000000.
- R2: While `leg_en` is high, every request with dword address 0x030 to 0x03F (byte 0xC0 to 0xFF) receives a completion.
- R3: Every request with dword address 0x100 to 0x3FF (byte 0x400 to 0xFFF) receives a completion only when both `ext_en` and `sn_cap_en` are high.
- R4: A request outside both windows, or inside a window that is disabled, produces no `done` pulse.
- R5: An accepted request produces exactly one `done` pulse, which is one cycle wide. If the strobe is sampled at clock edge k, `done` is high in the cycle after edge k+1.
- R6: Dwords 0x030 to 0x037 (legacy registers 0 to 7) and 0x100 to 0x103 (extended registers 0 to 3) are read/write registers. A read returns the last value written.
- R7: On a write, `req_be[i]` high updates bits 8i+7 to 8i of the register. Lanes with `req_be[i]` low keep their old value.
- R8: A read of any other offset inside an enabled window returns 0x00000000. A write to such an offset completes and changes no register.
- R9: A strobe that arrives while an earlier request is still in flight, up to and including the cycle in which its `done` is high, is ignored. It causes no pulse and no register change.
- R10: `rdata` is 0x00000000 in every cycle except the completion cycle of a read of an implemented register. This includes write completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leg_en | input | 1 | Legacy window enable |
| ext_en | input | 1 | Extended window enable |
| sn_cap_en | input | 1 | Serial-number capability present; gates the extended window |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Dword address (byte address bits 11:2) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid while `done` is high |

## Verification
The in-RTL assertions are checked on every cycle. They cover the following:
- `done` is one cycle wide.
- `done` comes exactly two cycles after an accepted strobe.
- No request is accepted in the cycle after another is accepted.
- Extended addresses are never claimed without both enables.
- `rdata` is zero outside read completions and on write completions.

Other behaviour can only be shown by the bench's scenarios:
- A read returns the value last written.
- Byte lanes merge correctly.
- Writes to unimplemented offsets and writes arriving while busy are really discarded.
- Registers clear on reset.

The bench shows these by sweeping all 1024 dword addresses under all eight enable combinations and comparing each result against a register model of its own.

// File: rtl/ucfg_pkg.sv
package ucfg_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  // Fixed window bounds in dword units (byte address >> 2)
  localparam logic [ADDR_W-1:0] LEG_FIRST = 10'h030;
  localparam logic [ADDR_W-1:0] LEG_LAST  = 10'h03F;
  localparam logic [ADDR_W-1:0] EXT_FIRST = 10'h100;
  localparam logic [ADDR_W-1:0] EXT_LAST  = 10'h3FF;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LEG  = 2'd1,
    WIN_EXT  = 2'd2
  } win_e;
endpackage

// File: rtl/ucfg_decode.sv
module ucfg_decode
  import ucfg_pkg::*;
#(
  parameter int LEG_REGS = 8,
  parameter int EXT_REGS = 4,
  parameter int IDX_W    = $clog2(LEG_REGS + EXT_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              leg_en,
  input  logic              ext_en,
  input  logic              sn_en,
  output logic              hit,
  output logic              impl,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] LEG_N = ADDR_W'(LEG_REGS);
  localparam logic [ADDR_W-1:0] EXT_N = ADDR_W'(EXT_REGS);

  logic              in_leg, in_ext, ext_live;
  logic [ADDR_W-1:0] leg_off, ext_off;

  // Compare one bit wider so the top bound is not a full-range constant
  assign in_leg   = ({1'b0, addr} >= {1'b0, LEG_FIRST}) && ({1'b0, addr} <= {1'b0, LEG_LAST});
  assign in_ext   = ({1'b0, addr} >= {1'b0, EXT_FIRST}) && ({1'b0, addr} <= {1'b0, EXT_LAST});
  assign ext_live = ext_en & sn_en;

  assign leg_off = addr - LEG_FIRST;
  assign ext_off = addr - EXT_FIRST;

  always_comb begin
    win  = WIN_NONE;
    impl = 1'b0;
    idx  = '0;
    if (in_leg && leg_en) begin
      win  = WIN_LEG;
      impl = (leg_off < LEG_N);
      idx  = IDX_W'(leg_off);
    end else if (in_ext && ext_live) begin
      win  = WIN_EXT;
      impl = (ext_off < EXT_N);
      idx  = IDX_W'(ext_off) + IDX_W'(LEG_REGS);
    end
  end

  assign hit = (win != WIN_NONE);
endmodule

// File: rtl/ucfg_regfile.sv
module ucfg_regfile #(
  parameter int DEPTH  = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // One write process per byte lane so each lane has its own enable
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i][8*b +: 8] <= 8'h00;
      end else if (we && be[b]) begin
        mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ucfg_responder.sv
module ucfg_responder
  import ucfg_pkg::*;
#(
  parameter int LEG_REGS = 8,
  parameter int EXT_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              leg_en,
  input  logic              ext_en,
  input  logic              sn_cap_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [9:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              done,
  output logic [31:0]       rdata
);
  localparam int DEPTH = LEG_REGS + EXT_REGS;
  localparam int IDX_W = $clog2(DEPTH);

  logic              dec_hit, dec_impl;
  win_e              dec_win;
  logic [IDX_W-1:0]  dec_idx;

  logic              busy, accept;
  logic              s1_valid, s1_write, s1_impl;
  logic [IDX_W-1:0]  s1_idx;
  logic [BE_W-1:0]   s1_be;
  logic [DATA_W-1:0] s1_wdata;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_we;

  ucfg_decode #(
    .LEG_REGS(LEG_REGS), .EXT_REGS(EXT_REGS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .leg_en(leg_en), .ext_en(ext_en), .sn_en(sn_cap_en),
    .hit(dec_hit), .impl(dec_impl), .win(dec_win), .idx(dec_idx)
  );

  assign busy   = s1_valid | done_q;
  assign accept = req_valid & ~busy & dec_hit;

  // Stage 1: capture the accepted request
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_impl  <= 1'b0;
      s1_idx   <= '0;
      s1_be    <= '0;
      s1_wdata <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_write <= req_write;
        s1_impl  <= dec_impl;
        s1_idx   <= dec_idx;
        s1_be    <= req_be;
        s1_wdata <= req_wdata;
      end
    end
  end

  assign rf_we = s1_valid & s1_write & s1_impl;

  ucfg_regfile #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .BE_W(BE_W)
  ) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .widx(s1_idx), .be(s1_be),
    .wdata(s1_wdata), .ridx(s1_idx), .rdata(rf_rdata)
  );

  // Stage 2: registered completion
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= s1_valid;
      rdata_q <= (s1_valid && s1_impl && !s1_write) ? rf_rdata : '0;
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;

  // R5: completion is one cycle wide
  assert_single_done_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5: completion arrives exactly two edges after acceptance
  assert_done_latency_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 done_q);

  // R9: no second request taken while the first is in flight
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> !s1_valid);

  // R3: extended window never claimed without both enables
  assert_ext_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_addr >= EXT_FIRST && !(ext_en && sn_cap_en)) |=> !s1_valid);

  // R10: write completions carry zero data
  assert_write_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> ##1 (rdata_q == '0));

  // R10: data bus is quiet outside completions
  assert_quiet_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> (rdata_q == '0));
endmodule

// File: tb/tb_ucfg_responder.sv
module tb_ucfg_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        leg_en, ext_en, sn_cap_en;
  logic        req_valid, req_write;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        done;
  logic [31:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] model [12];

  ucfg_responder dut (
    .clk(clk), .rst(rst), .leg_en(leg_en), .ext_en(ext_en), .sn_cap_en(sn_cap_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .done(done), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Returns model index, or -1 when the offset is not implemented
  function automatic int impl_index(input logic [9:0] a);
    if (a >= 10'h030 && a <= 10'h037) return int'(a) - 'h30;
    if (a >= 10'h100 && a <= 10'h103) return int'(a) - 'h100 + 8;
    return -1;
  endfunction

  function automatic bit claims(input logic [9:0] a);
    if (a >= 10'h030 && a <= 10'h03F && leg_en) return 1'b1;
    if (a >= 10'h100 && ext_en && sn_cap_en) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // One access, checked against the bench model; model updated on writes
  task automatic access(input bit wr, input logic [9:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string req);
    bit          resp = claims(a);
    int          ix   = impl_index(a);
    logic [31:0] exp  = 32'h0;
    if (resp && !wr && ix >= 0) exp = model[ix];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b0, "R5", "done early", 32'(done), 32'h0);
    @(negedge clk);
    check(done == resp, req, $sformatf("done addr %h", a), 32'(done), 32'(resp));
    check(rdata == exp, resp ? req : "R10", $sformatf("rdata addr %h", a), rdata, exp);
    @(negedge clk);
    check(done == 1'b0, "R5", "done width", 32'(done), 32'h0);
    if (resp && wr && ix >= 0) model[ix] = merge(model[ix], d, be);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) model[i] = 32'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    leg_en = 1; ext_en = 1; sn_cap_en = 1;
    do_reset();
    @(negedge clk);
    // R1: reset state at ports
    check(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
    check(rdata == 32'h0, "R1", "rdata after reset", rdata, 32'h0);
    for (int i = 0; i < 8; i++) access(1'b0, 10'(10'h030 + i), 32'h0, 4'h0, "R1");
    for (int i = 0; i < 4; i++) access(1'b0, 10'(10'h100 + i), 32'h0, 4'h0, "R1");

    // R6 / R10: full writes to each implemented register, then read back
    for (int i = 0; i < 8; i++)
      access(1'b1, 10'(10'h030 + i), 32'hA5000000 ^ (32'(i) * 32'h01030507), 4'hF, "R6");
    for (int i = 0; i < 4; i++)
      access(1'b1, 10'(10'h100 + i), 32'h5A00C300 ^ (32'(i) * 32'h11020304), 4'hF, "R6");
    for (int i = 0; i < 8; i++) access(1'b0, 10'(10'h030 + i), 32'h0, 4'h0, "R6");
    for (int i = 0; i < 4; i++) access(1'b0, 10'(10'h100 + i), 32'h0, 4'h0, "R6");

    // R7: every byte-enable pattern on one legacy and one extended register
    for (int m = 0; m < 16; m++) begin
      access(1'b1, 10'h032, 32'h01020304 * 32'(m + 1), 4'(m), "R7");
      access(1'b0, 10'h032, 32'h0, 4'h0, "R7");
      access(1'b1, 10'h103, 32'hF0E0D0C0 ^ (32'(m) * 32'h10101010), 4'(m), "R7");
      access(1'b0, 10'h103, 32'h0, 4'h0, "R7");
    end

    // R8: writes to unimplemented offsets are completed and discarded
    access(1'b1, 10'h038, 32'hDEADBEEF, 4'hF, "R8");
    access(1'b1, 10'h03F, 32'hDEADBEEF, 4'hF, "R8");
    access(1'b1, 10'h104, 32'hDEADBEEF, 4'hF, "R8");
    access(1'b1, 10'h3FF, 32'hDEADBEEF, 4'hF, "R8");
    // R4: writes outside the windows are not claimed
    access(1'b1, 10'h02F, 32'hDEADBEEF, 4'hF, "R4");
    access(1'b1, 10'h0FF, 32'hDEADBEEF, 4'hF, "R4");

    // R2/R3/R4/R8: sweep every address under every enable combination
    for (int c = 0; c < 8; c++) begin
      leg_en = c[0]; ext_en = c[1]; sn_cap_en = c[2];
      for (int a = 0; a < 1024; a++) begin
        string tag;
        if (a >= 'h30 && a <= 'h3F) tag = "R2";
        else if (a >= 'h100) tag = "R3";
        else tag = "R4";
        if (claims(10'(a)) && impl_index(10'(a)) < 0) tag = "R8";
        access(1'b0, 10'(a), 32'h0, 4'h0, tag);
      end
    end

    // R9: strobes while busy are ignored
    leg_en = 1; ext_en = 1; sn_cap_en = 1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'h030; req_wdata = 32'h11111111; req_be = 4'hF;
    @(negedge clk);
    req_addr = 10'h030; req_wdata = 32'h22222222;
    check(done == 1'b0, "R9", "done during busy", 32'(done), 32'h0);
    @(negedge clk);
    check(done == 1'b1, "R9", "first done", 32'(done), 32'h1);
    req_addr = 10'h031; req_wdata = 32'h33333333;
    @(negedge clk);
    req_valid = 0;
    check(done == 1'b0, "R9", "no second done", 32'(done), 32'h0);
    @(negedge clk);
    check(done == 1'b0, "R9", "no late done", 32'(done), 32'h0);
    model[0] = 32'h11111111;
    access(1'b0, 10'h030, 32'h0, 4'h0, "R9");
    access(1'b0, 10'h031, 32'h0, 4'h0, "R9");

    // R1: reset clears all registers
    do_reset();
    for (int i = 0; i < 8; i++) access(1'b0, 10'(10'h030 + i), 32'h0, 4'h0, "R1");
    for (int i = 0; i < 4; i++) access(1'b0, 10'(10'h100 + i), 32'h0, 4'h0, "R1");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule